// File: doc/BRIEF.md
# Chained Literal Prefix and Branch Offset Unit

This unit sits beside the return stack of a compact stack processor whose instructions are 8 bits wide (9 bits in a variant). It builds wide constants out of short instructions. A literal instruction carries a small immediate payload. The first literal in a run pushes that payload, sign-extended, onto the return stack. Each literal that follows in the same run shifts the constant on top of the stack left and appends its own payload. This lets a constant of any data width be assembled a few bits at a time.

Jump and call instructions carry only a short address field. When a literal run comes right before them, the field is appended to the constant on top of the return stack, which is popped to form the target. Without a preceding literal, the field alone is sign-extended into a short relative or absolute target. A call then pushes its return address, which the fetch logic supplies. All other opcodes count as general: they are not executed here and only end a literal run.

The fetch stage drives one instruction per cycle with a valid strobe. The unit reports the top of the return stack, one-cycle push and pop indications and the resolved branch target. All of these become visible one clock edge after the instruction.

Top module: `litext_unit`

## Requirements
- R1: After reset, `rs_top` is 0 and `lit_active`, `target_valid`, `rs_push` and `rs_pop` are all 0.
- R2: Decoding uses the following bits. The top bit (bit 7, or bit 8 in the 9-bit variant) set means literal, and the bits below it are the payload. Otherwise the three bits under the top bit select the kind: 000 is jump, 001 is call, and every other value is a general opcode. The low 4 bits (5 in the 9-bit variant) are the address field.
- R3: A literal arriving while `lit_active` is 0 pushes its payload, sign-extended to DW bits. One edge later, `rs_push` is 1, `rs_pop` is 0 and `lit_active` is 1.
- R4: A literal arriving while `lit_active` is 1 replaces the top with (top << payload width) | payload, truncated to DW bits. This causes neither a push nor a pop.
- R5: A jump or call arriving while `lit_active` is 1 gives the target ((top << field width) | field), truncated to DW bits, and pops that top value.
- R6: A jump or call arriving while `lit_active` is 0 gives the address field sign-extended to DW bits as the target. It does not pop.
- R7: A call pushes `ret_addr` after any pop, so `rs_top` then equals `ret_addr`. In the fused case both `rs_push` and `rs_pop` are 1.
- R8: Any non-literal instruction clears `lit_active`. A literal after a general opcode starts a new push.
- R9: A cycle with `instr_valid` low changes nothing. `rs_top` and `lit_active` hold, no push, pop or target is reported, and a literal run continues across the gap.
- R10: `target_valid` is high for exactly one cycle after each jump or call, and only then. `target_is_call` tells the two apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | IW (8 or 9) | Instruction word |
| ret_addr | input | DW | Return address pushed by a call |
| rs_top | output | DW | Current top of the return stack |
| rs_push | output | 1 | Last instruction pushed a value |
| rs_pop | output | 1 | Last instruction popped a value |
| lit_active | output | 1 | A literal run is in progress |
| target_valid | output | 1 | Branch target reported this cycle |
| target_is_call | output | 1 | Reported target belongs to a call |
| target_addr | output | DW | Resolved jump or call target |

## Verification
The stimulus includes several kinds of literal runs:
- a single positive literal, which separates a push from an extension;
- a negative first payload, which shows whether sign extension is applied;
- a three-literal run, which shows whether the high bits are truncated;
- a run broken by idle cycles, which shows whether bubbles end a run.

Jumps and calls are issued both after literal runs and on their own, with negative and positive fields. These cases separate fused from plain target formation, and show whether pop, push and the call's return address are handled in the right order. General opcodes from each unused class value show whether they end a run without touching the stack.

// File: rtl/litext_pkg.sv
package litext_pkg;

  localparam int unsigned WORD_MAX = 64;

  typedef logic [WORD_MAX-1:0] wide_t;

  typedef enum logic [1:0] {
    KIND_GEN  = 2'd0,
    KIND_JMP  = 2'd1,
    KIND_CALL = 2'd2,
    KIND_LIT  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    RS_HOLD = 2'd0,
    RS_PUSH = 2'd1,
    RS_POP  = 2'd2,
    RS_REPL = 2'd3
  } rs_op_e;

  // Ones in the low w bits.
  function automatic wide_t low_mask(int unsigned w);
    if (w >= WORD_MAX) return '1;
    return (wide_t'(1) << w) - wide_t'(1);
  endfunction

  // Treat the low w bits of v as a signed number.
  function automatic wide_t sign_extend(wide_t v, int unsigned w);
    wide_t m;
    m = low_mask(w);
    if (w == 0) return '0;
    if (v[w-1]) return (v & m) | ~m;
    return v & m;
  endfunction

  // Move base up by sh bits and drop low into the vacated bits.
  function automatic wide_t shift_insert(wide_t base, wide_t low, int unsigned sh);
    return (base << sh) | (low & low_mask(sh));
  endfunction

endpackage

// File: rtl/litext_decode.sv
module litext_decode
  import litext_pkg::*;
#(
  parameter int unsigned IW = 8,
  localparam int unsigned IMM_W = IW - 1,
  localparam int unsigned AF_W  = IW - 4
) (
  input  logic [IW-1:0]    instr,
  output kind_e            kind,
  output logic [IMM_W-1:0] imm,
  output logic [AF_W-1:0]  field
);

  logic [2:0] cls;

  assign cls   = instr[IW-2 -: 3];
  assign imm   = instr[IMM_W-1:0];
  assign field = instr[AF_W-1:0];

  always_comb begin
    if (instr[IW-1]) begin
      kind = KIND_LIT;
    end else begin
      unique case (cls)
        3'b000:  kind = KIND_JMP;
        3'b001:  kind = KIND_CALL;
        default: kind = KIND_GEN;
      endcase
    end
  end

endmodule

// File: rtl/litext_compose.sv
module litext_compose
  import litext_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned IMM_W = 7,
  parameter int unsigned AF_W  = 4
) (
  input  logic [DW-1:0]    top,
  input  logic [IMM_W-1:0] imm,
  input  logic [AF_W-1:0]  field,
  output logic [DW-1:0]    lit_first_val,
  output logic [DW-1:0]    lit_ext_val,
  output logic [DW-1:0]    fused_target,
  output logic [DW-1:0]    plain_target
);

  wide_t top_w, imm_w, field_w;
  wide_t first_w, ext_w, fused_w, plain_w;

  always_comb begin
    top_w   = wide_t'(top);
    imm_w   = wide_t'(imm);
    field_w = wide_t'(field);
    first_w = sign_extend(imm_w, IMM_W);
    ext_w   = shift_insert(top_w, imm_w, IMM_W);
    fused_w = shift_insert(top_w, field_w, AF_W);
    plain_w = sign_extend(field_w, AF_W);
  end

  assign lit_first_val = first_w[DW-1:0];
  assign lit_ext_val   = ext_w[DW-1:0];
  assign fused_target  = fused_w[DW-1:0];
  assign plain_target  = plain_w[DW-1:0];

endmodule

// File: rtl/litext_rstack.sv
module litext_rstack
  import litext_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SPW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rs_op_e        op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] top
);

  logic [DW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] wr_idx;
  logic           wr_en;

  assign wr_en  = (op == RS_PUSH) || (op == RS_REPL);
  assign wr_idx = (op == RS_PUSH) ? sp + SPW'(1) : sp;
  assign top    = mem[sp];

  // Circular pointer: depth is a power of two, so wrap is free.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
    end else begin
      unique case (op)
        RS_PUSH: sp <= sp + SPW'(1);
        RS_POP:  sp <= sp - SPW'(1);
        default: sp <= sp;
      endcase
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[e] <= '0;
      end else if (wr_en && (wr_idx == SPW'(e))) begin
        mem[e] <= wdata;
      end
    end
  end

endmodule

// File: rtl/litext_unit.sv
module litext_unit
  import litext_pkg::*;
#(
  parameter bit          WIDE9    = 1'b0,
  parameter int unsigned DW       = 16,
  parameter int unsigned RS_DEPTH = 8,
  localparam int unsigned IW      = WIDE9 ? 9 : 8,
  localparam int unsigned IMM_W   = IW - 1,
  localparam int unsigned AF_W    = IW - 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] ret_addr,
  output logic [DW-1:0] rs_top,
  output logic          rs_push,
  output logic          rs_pop,
  output logic          lit_active,
  output logic          target_valid,
  output logic          target_is_call,
  output logic [DW-1:0] target_addr
);

  kind_e            kind;
  logic [IMM_W-1:0] imm;
  logic [AF_W-1:0]  field;
  logic [DW-1:0]    lit_first_val, lit_ext_val, fused_target, plain_target;

  // Named events for the checker.
  logic ev_lit_first, ev_lit_ext, ev_branch, ev_fuse, ev_call;

  rs_op_e        st_op;
  logic [DW-1:0] st_wdata;
  logic [DW-1:0] tgt_next;
  logic          lit_next;

  litext_decode #(.IW(IW)) u_decode (
    .instr (instr),
    .kind  (kind),
    .imm   (imm),
    .field (field)
  );

  litext_compose #(.DW(DW), .IMM_W(IMM_W), .AF_W(AF_W)) u_compose (
    .top           (rs_top),
    .imm           (imm),
    .field         (field),
    .lit_first_val (lit_first_val),
    .lit_ext_val   (lit_ext_val),
    .fused_target  (fused_target),
    .plain_target  (plain_target)
  );

  litext_rstack #(.DW(DW), .DEPTH(RS_DEPTH)) u_rstack (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (st_op),
    .wdata (st_wdata),
    .top   (rs_top)
  );

  assign ev_lit_first = instr_valid && (kind == KIND_LIT) && !lit_active;
  assign ev_lit_ext   = instr_valid && (kind == KIND_LIT) &&  lit_active;
  assign ev_branch    = instr_valid && ((kind == KIND_JMP) || (kind == KIND_CALL));
  assign ev_fuse      = ev_branch && lit_active;
  assign ev_call      = instr_valid && (kind == KIND_CALL);

  always_comb begin
    st_op    = RS_HOLD;
    st_wdata = lit_first_val;
    if (ev_lit_first) begin
      st_op    = RS_PUSH;
      st_wdata = lit_first_val;
    end else if (ev_lit_ext) begin
      st_op    = RS_REPL;
      st_wdata = lit_ext_val;
    end else if (ev_call) begin
      // Pop of the fused value followed by push of the return address.
      st_op    = ev_fuse ? RS_REPL : RS_PUSH;
      st_wdata = ret_addr;
    end else if (ev_fuse) begin
      st_op    = RS_POP;
    end
  end

  assign tgt_next = ev_fuse ? fused_target : plain_target;
  assign lit_next = instr_valid ? (kind == KIND_LIT) : lit_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lit_active     <= 1'b0;
      rs_push        <= 1'b0;
      rs_pop         <= 1'b0;
      target_valid   <= 1'b0;
      target_is_call <= 1'b0;
      target_addr    <= '0;
    end else begin
      lit_active     <= lit_next;
      rs_push        <= ev_lit_first || ev_call;
      rs_pop         <= ev_fuse;
      target_valid   <= ev_branch;
      target_is_call <= ev_call;
      if (ev_branch) target_addr <= tgt_next;
    end
  end

endmodule

// File: rtl/litext_unit_chk.sv
module litext_unit_chk #(
  parameter int unsigned IW = 8,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [IW-1:0] instr,
  input logic [DW-1:0] ret_addr,
  input logic [DW-1:0] rs_top,
  input logic          rs_push,
  input logic          rs_pop,
  input logic          lit_active,
  input logic          target_valid,
  input logic          target_is_call,
  input logic          ev_lit_first,
  input logic          ev_lit_ext,
  input logic          ev_fuse,
  input logic          ev_call
);

  logic is_lit, is_jmp, is_call;
  assign is_lit  = instr_valid &&  instr[IW-1];
  assign is_jmp  = instr_valid && !instr[IW-1] && (instr[IW-2 -: 3] == 3'b000);
  assign is_call = instr_valid && !instr[IW-1] && (instr[IW-2 -: 3] == 3'b001);

  p_first_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_lit && !lit_active |=> rs_push && !rs_pop && lit_active);

  p_ext_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lit_ext |=> !rs_push && !rs_pop && lit_active);

  p_fuse_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_jmp && lit_active |=> rs_pop && !rs_push);

  p_plain_nopop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp || is_call) && !lit_active |=> !rs_pop);

  p_call_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_call |=> rs_push && target_is_call && (rs_top == $past(ret_addr)));

  p_run_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !instr[IW-1] |=> !lit_active);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(rs_top) && $stable(lit_active)
                     && !rs_push && !rs_pop && !target_valid);

  p_target_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jmp || is_call) |=> target_valid);

  p_target_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_jmp || is_call) |=> !target_valid && !target_is_call);

  p_event_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_lit_first, ev_lit_ext, ev_fuse}) <= 1);

  p_call_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |-> is_call);

endmodule

bind litext_unit litext_unit_chk #(.IW(IW), .DW(DW)) u_litext_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .instr_valid    (instr_valid),
  .instr          (instr),
  .ret_addr       (ret_addr),
  .rs_top         (rs_top),
  .rs_push        (rs_push),
  .rs_pop         (rs_pop),
  .lit_active     (lit_active),
  .target_valid   (target_valid),
  .target_is_call (target_is_call),
  .ev_lit_first   (ev_lit_first),
  .ev_lit_ext     (ev_lit_ext),
  .ev_fuse        (ev_fuse),
  .ev_call        (ev_call)
);

// File: tb/test_litext_unit.sv
module test_litext_unit;

  localparam int DW = 16;
  localparam int IW = 8;
  localparam int PW = 7;   // literal payload width
  localparam int FW = 4;   // address field width
  localparam longint MASK = (64'sd1 <<< DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic [IW-1:0] instr = '0;
  logic [DW-1:0] ret_addr = '0;
  logic [DW-1:0] rs_top;
  logic          rs_push, rs_pop, lit_active, target_valid, target_is_call;
  logic [DW-1:0] target_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  litext_unit #(.WIDE9(1'b0), .DW(DW), .RS_DEPTH(8)) i_litext_unit (
    .clk, .rst_n, .instr_valid, .instr, .ret_addr, .rs_top, .rs_push,
    .rs_pop, .lit_active, .target_valid, .target_is_call, .target_addr
  );

  // Behavioural reference state.
  longint stk[$];
  bit     m_lit = 0;
  longint e_tgt = 0;
  bit     e_push, e_pop, e_tv, e_call;
  string  tag;

  function automatic longint sx(longint v, int w);
    longint m = (64'sd1 <<< w) - 1;
    v = v & m;
    if (v[w-1]) v = v | ~m;
    return v & MASK;
  endfunction

  function automatic longint top_of();
    return (stk.size() == 0) ? 0 : stk[$];
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [IW-1:0] ins);
    longint t;
    instr_valid = v;
    instr       = ins;
    ret_addr    = ret_addr + 16'h0111;
    e_push = 0; e_pop = 0; e_tv = 0; e_call = 0;
    if (!v) begin
      tag = "R9";
    end else if (ins[7]) begin
      if (!m_lit) begin
        stk.push_back(sx(longint'(ins[6:0]), PW));
        e_push = 1; tag = "R3";
      end else begin
        t = stk.pop_back();
        stk.push_back(((t <<< PW) | longint'(ins[6:0])) & MASK);
        tag = "R4";
      end
      m_lit = 1;
    end else if (ins[6:4] == 3'b000 || ins[6:4] == 3'b001) begin
      e_tv = 1;
      e_call = (ins[6:4] == 3'b001);
      if (m_lit) begin
        t = stk.pop_back();
        e_tgt = ((t <<< FW) | longint'(ins[3:0])) & MASK;
        e_pop = 1; tag = "R5";
      end else begin
        e_tgt = sx(longint'(ins[3:0]), FW);
        tag = "R6";
      end
      if (e_call) begin
        stk.push_back(longint'(ret_addr));
        e_push = 1; tag = {tag, "/R7"};
      end
      m_lit = 0;
    end else begin
      m_lit = 0; tag = "R8";
    end
    @(posedge clk);
    #1;
    chk(tag, "rs_top", longint'(rs_top), top_of());
    chk(tag, "lit_active", longint'(lit_active), longint'(m_lit));
    chk(tag, "rs_push", longint'(rs_push), longint'(e_push));
    chk(tag, "rs_pop", longint'(rs_pop), longint'(e_pop));
    chk("R10", "target_valid", longint'(target_valid), longint'(e_tv));
    if (e_tv) begin
      chk(tag, "target_addr", longint'(target_addr), e_tgt);
      chk("R10", "target_is_call", longint'(target_is_call), longint'(e_call));
    end
    @(negedge clk);
  endtask

  function automatic logic [7:0] lit(int p);  return 8'h80 | 8'(p & 8'h7F); endfunction
  function automatic logic [7:0] jmp(int f);  return 8'h00 | 8'(f & 4'hF);  endfunction
  function automatic logic [7:0] cal(int f);  return 8'h10 | 8'(f & 4'hF);  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rs_top", longint'(rs_top), 0);
    chk("R1", "lit_active", longint'(lit_active), 0);
    chk("R1", "target_valid", longint'(target_valid), 0);
    chk("R1", "rs_push", longint'(rs_push), 0);
    chk("R1", "rs_pop", longint'(rs_pop), 0);

    step(1, 8'h20);                        // R8 general
    step(1, lit(8'h05)); step(1, 8'h20);   // R3 positive payload
    step(1, lit(8'h7F)); step(1, lit(8'h01)); step(1, 8'h30); // R3 negative, R4
    step(1, lit(8'h12)); step(1, jmp(3));  // R5 fused jump
    step(1, jmp(4'hA)); step(1, jmp(5));   // R6 negative and positive field
    step(1, lit(8'h01)); step(1, lit(8'h23)); step(1, cal(4)); // R5/R7 fused call
    step(1, cal(9));                       // R6/R7 plain call
    step(1, lit(8'h40)); step(0, 8'h20); step(0, 8'h00); step(1, lit(8'h02)); // R9 gap in run
    step(1, jmp(0));                       // R5 after gapped run
    step(1, lit(8'h7F)); step(1, lit(8'h7F)); step(1, lit(8'h7F)); // R4 truncation
    step(1, 8'h20);                        // R2 general codes
    step(1, 8'h35); step(1, 8'h40); step(1, 8'h70);
    step(1, lit(8'h3F)); step(1, jmp(4'hF));
    step(1, lit(8'h11)); step(1, 8'h50); step(1, lit(8'h22)); // R8 new push after general
    step(1, cal(4'hF));
    step(0, 8'h80);                        // R9 idle with literal pattern

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule